// File: doc/BRIEF.md
# Packed 128-bit Integer Vector ALU

This unit applies one integer or bitwise operation to 128-bit packed vectors each cycle and registers the answer. The lane width is chosen per operation by a shape code: sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Each lane is computed on its own, and no carry or borrow crosses a lane boundary. The bitwise operations ignore the shape and act on all 128 bits at once.

A caller presents operands A, B and C, an opcode, a shape, a signedness flag and a 32-bit shift count, together with `in_valid`. One clock later the unit returns a 128-bit vector, a single-bit flag for the two test operations, and an illegal indication. The illegal indication is raised for opcode and shape pairs the instruction set does not define, such as saturation on 32-bit lanes or multiply on 8-bit lanes. Bitmask gathers the top bit of every lane into a small scalar at the bottom of the result.

Top module: `vec_int_alu`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted operation, `out_valid`, `out_vec`, `out_flag` and `out_illegal` are all zero.
- R2: An operation accepted with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. A cycle with `in_valid` low drives `out_valid` low and holds `out_vec`, `out_flag` and `out_illegal` unchanged.
- R3: The bitwise opcodes act on all 128 bits for every shape: 0 not A, 1 A and B, 2 A and not B, 3 A or B, 4 A xor B, 5 bit-select, which takes each bit from A where C is 1 and from B where C is 0.
- R4: Per-lane modular arithmetic keeps the low lane bits: 6 add, 7 subtract, 8 negate, 9 absolute value (of the signed lane), 15 multiply. Carries do not cross lanes.
- R5: Opcode 10 (saturating add) and opcode 11 (saturating subtract) clamp to the lane's signed range when `in_signed` is 1, and to its unsigned range when it is 0.
- R6: Opcode 14 gives the unsigned rounding average (a + b + 1) >> 1 per lane, computed without loss of the carry. `in_signed` has no effect on it.
- R7: Opcode 12 (min) and opcode 13 (max) pick a lane of A or B using a signed ordering when `in_signed` is 1 and an unsigned ordering when it is 0.
- R8: Compares write all ones into a lane when true and all zeros when false: 16 eq, 17 ne, 18 lt, 19 gt, 20 le, 21 ge. The ordering compares follow `in_signed`.
- R9: Opcode 22 shifts each lane left, and opcode 23 shifts it right (arithmetic when `in_signed` is 1, logical when 0). In both cases the count is `in_count` modulo the lane width.
- R10: Opcode 24 sets `out_flag` when any bit of A is 1. Opcode 25 sets `out_flag` when every lane of A is nonzero. Both return a zero vector. `out_flag` is 0 for every other opcode.
- R11: Opcode 26 returns a vector whose bit i is the most significant bit of lane i of A. All bits from the lane count upward are zero.
- R12: Shape codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit lanes. The following pairs are illegal: opcodes 10, 11 and 14 with shape 2 or 3; opcodes 12 and 13 with shape 3; opcode 15 with shape 0; opcodes 9, 25 and 26 with shape 3; and any opcode above 26. An illegal operation gives `out_illegal` = 1 with a zero vector and a zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operation on this edge |
| in_op | input | 5 | Opcode |
| in_shape | input | 2 | Lane width selector |
| in_signed | input | 1 | Signed interpretation for saturation, min/max, ordering compares and right shift |
| in_a | input | 128 | Operand A |
| in_b | input | 128 | Operand B |
| in_c | input | 128 | Select mask for bit-select |
| in_count | input | 32 | Shift count |
| out_valid | output | 1 | Registered result is new this cycle |
| out_vec | output | 128 | Vector result |
| out_flag | output | 1 | Test result |
| out_illegal | output | 1 | Opcode and shape pair not defined |

## Verification
The properties assume that `in_op` and `in_shape` are stable and known in any cycle where `in_valid` is high, and that reset is released between edges. The bench drives all inputs only on falling edges, so every sample sees settled values. The stimulus walks through every opcode code, including the undefined ones, against all four shapes, and it mixes random operands with lane-aligned extremes (0x80, 0x7F, all ones, alternating zero bytes) that exercise the saturation, sign and zero-lane corners. Idle cycles with changed operands are inserted at random to check that the outputs hold.

// File: rtl/vialu_pkg.sv
package vialu_pkg;

    typedef enum logic [4:0] {
        OP_NOT   = 5'd0,
        OP_AND   = 5'd1,
        OP_ANDN  = 5'd2,
        OP_OR    = 5'd3,
        OP_XOR   = 5'd4,
        OP_BSEL  = 5'd5,
        OP_ADD   = 5'd6,
        OP_SUB   = 5'd7,
        OP_NEG   = 5'd8,
        OP_ABS   = 5'd9,
        OP_ADDS  = 5'd10,
        OP_SUBS  = 5'd11,
        OP_MIN   = 5'd12,
        OP_MAX   = 5'd13,
        OP_AVGR  = 5'd14,
        OP_MUL   = 5'd15,
        OP_EQ    = 5'd16,
        OP_NE    = 5'd17,
        OP_LT    = 5'd18,
        OP_GT    = 5'd19,
        OP_LE    = 5'd20,
        OP_GE    = 5'd21,
        OP_SHL   = 5'd22,
        OP_SHR   = 5'd23,
        OP_ANYT  = 5'd24,
        OP_ALLT  = 5'd25,
        OP_BMASK = 5'd26
    } vop_e;

    typedef enum logic [1:0] {
        SH_B8  = 2'd0,
        SH_B16 = 2'd1,
        SH_B32 = 2'd2,
        SH_B64 = 2'd3
    } vshape_e;

    localparam int NUM_SHAPES = 4;

    function automatic logic op_is_bitwise(input logic [4:0] op);
        return op <= 5'(OP_BSEL);
    endfunction

    // Which opcode and shape pairs the instruction set defines
    function automatic logic op_is_legal(input logic [4:0] op, input logic [1:0] sh);
        logic ok;
        ok = 1'b1;
        if (op > 5'(OP_BMASK)) begin
            ok = 1'b0;
        end else if (op == 5'(OP_ADDS) || op == 5'(OP_SUBS) || op == 5'(OP_AVGR)) begin
            ok = (sh == 2'(SH_B8)) || (sh == 2'(SH_B16));
        end else if (op == 5'(OP_MIN) || op == 5'(OP_MAX)) begin
            ok = (sh != 2'(SH_B64));
        end else if (op == 5'(OP_MUL)) begin
            ok = (sh != 2'(SH_B8));
        end else if (op == 5'(OP_ABS) || op == 5'(OP_ALLT) || op == 5'(OP_BMASK)) begin
            ok = (sh != 2'(SH_B64));
        end
        return ok;
    endfunction

endpackage

// File: rtl/vialu_bitwise.sv
module vialu_bitwise
    import vialu_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  vop_e              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        y = '0;
        case (op)
            OP_NOT:  y = ~a;
            OP_AND:  y = a & b;
            OP_ANDN: y = a & ~b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_BSEL: y = (a & c) | (b & ~c);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vialu_lane.sv
module vialu_lane
    import vialu_pkg::*;
#(
    parameter  int LANE_W = 8,
    localparam int SH_W   = $clog2(LANE_W)
) (
    input  vop_e              op,
    input  logic              sgn,
    input  logic [SH_W-1:0]   cnt,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] r
);

    logic [LANE_W:0]          uadd;
    logic [LANE_W:0]          usub;
    logic [LANE_W:0]          sadd;
    logic [LANE_W:0]          ssub;
    logic [LANE_W:0]          avg_sum;
    logic [LANE_W-1:0]        smax;
    logic [LANE_W-1:0]        smin;
    logic [LANE_W-1:0]        neg_a;
    logic [LANE_W-1:0]        ka;
    logic [LANE_W-1:0]        kb;
    logic                     lt;
    logic                     eq;
    logic signed [LANE_W-1:0] a_s;
    logic signed [LANE_W-1:0] sra;
    logic [LANE_W-1:0]        srl;

    always_comb begin
        smax    = {1'b0, {(LANE_W-1){1'b1}}};
        smin    = ~smax;
        uadd    = {1'b0, a} + {1'b0, b};
        usub    = {1'b0, a} - {1'b0, b};
        sadd    = {a[LANE_W-1], a} + {b[LANE_W-1], b};
        ssub    = {a[LANE_W-1], a} - {b[LANE_W-1], b};
        avg_sum = uadd + {{LANE_W{1'b0}}, 1'b1};
        // Flipping the sign bit turns a signed order into an unsigned one
        ka      = {a[LANE_W-1] ^ sgn, a[LANE_W-2:0]};
        kb      = {b[LANE_W-1] ^ sgn, b[LANE_W-2:0]};
        lt      = ka < kb;
        eq      = a == b;
        neg_a   = '0 - a;
        a_s     = a;
        sra     = a_s >>> cnt;
        srl     = a >> cnt;

        r = '0;
        case (op)
            OP_ADD:  r = uadd[LANE_W-1:0];
            OP_SUB:  r = usub[LANE_W-1:0];
            OP_NEG:  r = neg_a;
            OP_ABS:  r = a[LANE_W-1] ? neg_a : a;
            OP_ADDS: begin
                if (sgn) begin
                    if (sadd[LANE_W] != sadd[LANE_W-1]) r = sadd[LANE_W] ? smin : smax;
                    else                                r = sadd[LANE_W-1:0];
                end else begin
                    r = uadd[LANE_W] ? '1 : uadd[LANE_W-1:0];
                end
            end
            OP_SUBS: begin
                if (sgn) begin
                    if (ssub[LANE_W] != ssub[LANE_W-1]) r = ssub[LANE_W] ? smin : smax;
                    else                                r = ssub[LANE_W-1:0];
                end else begin
                    r = usub[LANE_W] ? '0 : usub[LANE_W-1:0];
                end
            end
            OP_MIN:  r = lt ? a : b;
            OP_MAX:  r = lt ? b : a;
            OP_AVGR: r = avg_sum[LANE_W:1];
            OP_MUL:  r = a * b;
            OP_EQ:   r = {LANE_W{eq}};
            OP_NE:   r = {LANE_W{~eq}};
            OP_LT:   r = {LANE_W{lt}};
            OP_GT:   r = {LANE_W{~lt & ~eq}};
            OP_LE:   r = {LANE_W{lt | eq}};
            OP_GE:   r = {LANE_W{~lt}};
            OP_SHL:  r = a << cnt;
            OP_SHR:  r = sgn ? sra : srl;
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/vialu_shape.sv
module vialu_shape
    import vialu_pkg::*;
#(
    parameter  int DATA_W  = 128,
    parameter  int LANE_W  = 8,
    parameter  int MASK_W  = 16,
    localparam int N_LANES = DATA_W / LANE_W,
    localparam int SH_W    = $clog2(LANE_W)
) (
    input  vop_e              op,
    input  logic              sgn,
    input  logic [SH_W-1:0]   cnt,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] vec,
    output logic              all_nz,
    output logic [MASK_W-1:0] msb_mask
);

    logic [N_LANES-1:0] lane_nz;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        vialu_lane #(.LANE_W(LANE_W)) u_lane (
            .op  (op),
            .sgn (sgn),
            .cnt (cnt),
            .a   (a[i*LANE_W +: LANE_W]),
            .b   (b[i*LANE_W +: LANE_W]),
            .r   (vec[i*LANE_W +: LANE_W])
        );
        assign lane_nz[i]  = |a[i*LANE_W +: LANE_W];
        assign msb_mask[i] = a[i*LANE_W + LANE_W - 1];
    end

    if (MASK_W > N_LANES) begin : g_pad
        assign msb_mask[MASK_W-1:N_LANES] = '0;
    end

    assign all_nz = &lane_nz;

endmodule

// File: rtl/vec_int_alu.sv
module vec_int_alu
    import vialu_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int MIN_LANE_W = 8,
    parameter int CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        in_op,
    input  logic [1:0]        in_shape,
    input  logic              in_signed,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    input  logic [CNT_W-1:0]  in_count,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_vec,
    output logic              out_flag,
    output logic              out_illegal
);

    localparam int MASK_W  = DATA_W / MIN_LANE_W;
    localparam int MAX_SHW = $clog2(MIN_LANE_W << (NUM_SHAPES - 1));

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] vec;
        logic              flag;
        logic              illegal;
    } out_st_t;

    out_st_t st_d;
    out_st_t st_q;

    vop_e              op_e;
    logic [DATA_W-1:0] bw_vec;
    logic [DATA_W-1:0] shp_vec  [NUM_SHAPES];
    logic [MASK_W-1:0] shp_mask [NUM_SHAPES];
    logic [NUM_SHAPES-1:0] shp_allnz;
    logic              legal;
    logic              unused_cnt_hi;

    assign op_e          = vop_e'(in_op);
    assign unused_cnt_hi = ^in_count[CNT_W-1:MAX_SHW];

    vialu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .op (op_e),
        .a  (in_a),
        .b  (in_b),
        .c  (in_c),
        .y  (bw_vec)
    );

    for (genvar s = 0; s < NUM_SHAPES; s++) begin : g_shape
        localparam int LW = MIN_LANE_W << s;
        localparam int SW = $clog2(LW);
        vialu_shape #(
            .DATA_W (DATA_W),
            .LANE_W (LW),
            .MASK_W (MASK_W)
        ) u_shape (
            .op       (op_e),
            .sgn      (in_signed),
            .cnt      (in_count[SW-1:0]),
            .a        (in_a),
            .b        (in_b),
            .vec      (shp_vec[s]),
            .all_nz   (shp_allnz[s]),
            .msb_mask (shp_mask[s])
        );
    end

    assign legal = op_is_legal(in_op, in_shape);

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.vec     = '0;
            st_d.flag    = 1'b0;
            st_d.illegal = ~legal;
            if (legal) begin
                if (op_is_bitwise(in_op)) begin
                    st_d.vec = bw_vec;
                end else begin
                    case (op_e)
                        OP_ANYT:  st_d.flag = |in_a;
                        OP_ALLT:  st_d.flag = shp_allnz[in_shape];
                        OP_BMASK: st_d.vec  = DATA_W'(shp_mask[in_shape]);
                        default:  st_d.vec  = shp_vec[in_shape];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_vec     = st_q.vec;
    assign out_flag    = st_q.flag;
    assign out_illegal = st_q.illegal;

endmodule

// File: rtl/vialu_checker.sv
module vialu_checker
    import vialu_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [4:0]        in_op,
    input logic [1:0]        in_shape,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_vec,
    input logic              out_flag,
    input logic              out_illegal
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_flag) && $stable(out_illegal))); // R2

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_vec == '0 && !out_flag)); // R12

    AST_NARROW_ONLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 5'(OP_ADDS) || in_op == 5'(OP_SUBS)) && in_shape >= 2'd2)
        |=> out_illegal); // R5

    AST_NARROW_ONLY_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 5'(OP_AVGR) && in_shape >= 2'd2) |=> out_illegal); // R6

    AST_NO_BYTE_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 5'(OP_MUL) && in_shape == 2'd0) |=> out_illegal); // R12

    AST_FLAG_TEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 5'(OP_ANYT) && in_op != 5'(OP_ALLT)) |=> !out_flag); // R10

    AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 5'(OP_BMASK) && in_shape != 2'd3)
        |=> (out_vec[DATA_W-1:MASK_W] == '0 && !out_illegal)); // R11

    AST_BITWISE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 5'(OP_BSEL)) |=> !out_illegal); // R3

endmodule

bind vec_int_alu vialu_checker #(
    .DATA_W (DATA_W),
    .MASK_W (MASK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_shape    (in_shape),
    .out_valid   (out_valid),
    .out_vec     (out_vec),
    .out_flag    (out_flag),
    .out_illegal (out_illegal)
);

// File: tb/vec_int_alu_tb.sv
module vec_int_alu_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [4:0]   in_op;
    logic [1:0]   in_shape;
    logic         in_signed;
    logic [127:0] in_a, in_b, in_c;
    logic [31:0]  in_count;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_flag;
    logic         out_illegal;

    always #2 clk = ~clk;

    vec_int_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_shape(in_shape), .in_signed(in_signed), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .in_count(in_count), .out_valid(out_valid),
        .out_vec(out_vec), .out_flag(out_flag), .out_illegal(out_illegal)
    );

    int           n_vec = 0;
    int           n_bad = 0;
    logic         e_valid;
    logic [127:0] e_vec;
    logic         e_flag;
    logic         e_ill;
    string        e_req;

    function automatic logic signed [66:0] ext(input logic [63:0] x, input int w, input bit s);
        logic signed [66:0] v;
        v = $signed({3'b000, x});
        if (s && x[w-1]) v = v - (67'sd1 <<< w);
        return v;
    endfunction

    function automatic logic [63:0] lane_ref(input int op, input int w, input bit s,
                                             input logic [63:0] ai, input logic [63:0] bi,
                                             input logic [31:0] cnt);
        logic [63:0] m, a, b;
        logic signed [66:0] va, vb, t, hi, lo;
        int k;
        bit c;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        a  = ai & m;
        b  = bi & m;
        va = ext(a, w, s);
        vb = ext(b, w, s);
        k  = int'(cnt % 32'(w));
        case (op)
            6:  return (a + b) & m;
            7:  return (a - b) & m;
            8:  return (64'd0 - a) & m;
            9:  begin t = ext(a, w, 1'b1); if (t < 0) t = -t; return t[63:0] & m; end
            10, 11: begin
                t  = (op == 10) ? va + vb : va - vb;
                hi = s ? ((67'sd1 <<< (w-1)) - 67'sd1) : ((67'sd1 <<< w) - 67'sd1);
                lo = s ? -(67'sd1 <<< (w-1)) : 67'sd0;
                if (t > hi) t = hi;
                if (t < lo) t = lo;
                return t[63:0] & m;
            end
            12: return (va < vb) ? a : b;
            13: return (va > vb) ? a : b;
            14: begin t = (ext(a, w, 1'b0) + ext(b, w, 1'b0) + 67'sd1) >>> 1; return t[63:0] & m; end
            15: return (a * b) & m;
            16, 17, 18, 19, 20, 21: begin
                case (op)
                    16: c = (va == vb);
                    17: c = (va != vb);
                    18: c = (va < vb);
                    19: c = (va > vb);
                    20: c = (va <= vb);
                    default: c = (va >= vb);
                endcase
                return c ? m : 64'd0;
            end
            22: return (a << k) & m;
            23: begin t = va >>> k; return t[63:0] & m; end
            default: return 64'd0;
        endcase
    endfunction

    function automatic bit legal_ref(input int op, input int w);
        if (op > 26) return 1'b0;
        if (op == 10 || op == 11 || op == 14) return w <= 16;
        if (op == 12 || op == 13) return w <= 32;
        if (op == 15) return w >= 16;
        if (op == 9 || op == 25 || op == 26) return w <= 32;
        return 1'b1;
    endfunction

    function automatic string req_of(input int op);
        if (op <= 5) return "R3";
        if (op <= 9 || op == 15) return "R4";
        if (op <= 11) return "R5";
        if (op <= 13) return "R7";
        if (op == 14) return "R6";
        if (op <= 21) return "R8";
        if (op <= 23) return "R9";
        if (op <= 25) return "R10";
        return "R11";
    endfunction

    task automatic model(input int op, input int shp, input bit s,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] c, input logic [31:0] cnt);
        int w;
        int lanes;
        w      = 8 << shp;
        lanes  = 128 / w;
        e_vec  = '0;
        e_flag = 1'b0;
        e_ill  = !legal_ref(op, w);
        e_req  = e_ill ? "R12" : req_of(op);
        if (!e_ill) begin
            case (op)
                0: e_vec = ~a;
                1: e_vec = a & b;
                2: e_vec = a & ~b;
                3: e_vec = a | b;
                4: e_vec = a ^ b;
                5: e_vec = (a & c) | (b & ~c);
                24: e_flag = |a;
                25: begin
                    e_flag = 1'b1;
                    for (int i = 0; i < lanes; i++)
                        if (((64'(a >> (i*w))) & ((w == 64) ? '1 : ((64'd1 << w) - 64'd1))) == 64'd0)
                            e_flag = 1'b0;
                end
                26: for (int i = 0; i < lanes; i++) e_vec[i] = a[i*w + w - 1];
                default: begin
                    for (int i = 0; i < lanes; i++) begin
                        logic [63:0] r;
                        r = lane_ref(op, w, s, 64'(a >> (i*w)), 64'(b >> (i*w)), cnt);
                        e_vec = e_vec | (128'(r) << (i*w));
                    end
                end
            endcase
        end
    endtask

    task automatic compare();
        n_vec++;
        if (out_valid !== e_valid || out_vec !== e_vec || out_flag !== e_flag || out_illegal !== e_ill) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b vec=%h flag=%0b ill=%0b, expected valid=%0b vec=%h flag=%0b ill=%0b",
                     e_req, out_valid, out_vec, out_flag, out_illegal, e_valid, e_vec, e_flag, e_ill);
        end
    endtask

    task automatic step(input bit v, input int op, input int shp, input bit s,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] c, input logic [31:0] cnt);
        @(negedge clk);
        compare();
        in_valid  = v;
        in_op     = 5'(op);
        in_shape  = 2'(shp);
        in_signed = s;
        in_a      = a;
        in_b      = b;
        in_c      = c;
        in_count  = cnt;
        e_valid   = v;
        if (v) model(op, shp, s, a, b, c, cnt);
        else   e_req = "R2";
    endtask

    function automatic logic [127:0] pick_vec();
        logic [127:0] v;
        int sel;
        v   = {$urandom(), $urandom(), $urandom(), $urandom()};
        sel = $urandom_range(0, 7);
        case (sel)
            0: v = '1;
            1: v = {16{8'h80}};
            2: v = {16{8'h7F}};
            3: v = {8{16'h8000}};
            4: v = v & {4{32'hFF00_FF00}};
            default: ;
        endcase
        return v;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] ra, rb, rc;
        rst_n = 1'b0; in_valid = 1'b1; in_op = 5'd6; in_shape = 2'd0; in_signed = 1'b0;
        in_a = '1; in_b = '1; in_c = '0; in_count = '0;
        e_valid = 1'b0; e_vec = '0; e_flag = 1'b0; e_ill = 1'b0; e_req = "R1";
        // R1: reset state while inputs are active
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1; in_valid = 1'b0;
        step(0, 6, 0, 0, '0, '0, '0, 0); e_req = "R1";

        // R3 bitwise, shape ignored
        step(1, 0, 3, 0, {32{4'hA}}, '0, '0, 0);
        step(1, 2, 1, 1, '1, {32{4'h5}}, '0, 0);
        step(1, 5, 2, 0, {16{8'hF0}}, {16{8'h0F}}, {8{16'h00FF}}, 0);
        // R2 idle holds
        step(0, 1, 0, 0, '1, '1, '1, 0);
        step(0, 3, 1, 0, '0, '0, '0, 0);
        // R4 lane wrap, no carry across lanes
        step(1, 6, 0, 0, {16{8'hFF}}, {16{8'h01}}, '0, 0);
        step(1, 9, 1, 0, {8{16'h8000}}, '0, '0, 0);
        step(1, 15, 3, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'd3}}, '0, 0);
        // R5 saturation
        step(1, 10, 0, 1, {16{8'h7F}}, {16{8'h01}}, '0, 0);
        step(1, 10, 0, 0, {16{8'hFF}}, {16{8'h01}}, '0, 0);
        step(1, 11, 1, 1, {8{16'h8000}}, {8{16'h0001}}, '0, 0);
        step(1, 11, 0, 0, '0, {16{8'h01}}, '0, 0);
        // R6 rounding average
        step(1, 14, 0, 1, {16{8'hFF}}, {16{8'hFF}}, '0, 0);
        step(1, 14, 1, 0, {8{16'h0000}}, {8{16'h0001}}, '0, 0);
        // R7 min/max signed vs unsigned
        step(1, 12, 0, 1, {16{8'h80}}, {16{8'h01}}, '0, 0);
        step(1, 12, 0, 0, {16{8'h80}}, {16{8'h01}}, '0, 0);
        step(1, 13, 2, 1, {4{32'hFFFF_FFFF}}, {4{32'd5}}, '0, 0);
        // R8 compares
        step(1, 18, 3, 1, {64'h8000_0000_0000_0000, 64'd1}, {64'd0, 64'd2}, '0, 0);
        step(1, 21, 0, 0, {16{8'h80}}, {16{8'h7F}}, '0, 0);
        // R9 shift count wraps
        step(1, 22, 0, 0, {16{8'h41}}, '0, '0, 32'd9);
        step(1, 23, 0, 1, {16{8'h80}}, '0, '0, 32'd1);
        step(1, 23, 2, 0, {4{32'h8000_0000}}, '0, '0, 32'd35);
        // R10 tests
        step(1, 24, 3, 0, 128'd1, '0, '0, 0);
        step(1, 25, 0, 0, {{15{8'h01}}, 8'h00}, '0, '0, 0);
        step(1, 25, 1, 0, {8{16'h0100}}, '0, '0, 0);
        // R11 bitmask
        step(1, 26, 0, 0, {8{16'h8000}}, '0, '0, 0);
        step(1, 26, 2, 0, {32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 32'd1}, '0, '0, 0);
        // R12 illegal pairs
        step(1, 10, 2, 0, '1, '1, '0, 0);
        step(1, 15, 0, 0, '1, '1, '0, 0);
        step(1, 30, 1, 0, '1, '1, '0, 0);
        step(1, 26, 3, 0, '1, '0, '0, 0);

        for (int n = 0; n < 4000; n++) begin
            ra = pick_vec(); rb = pick_vec(); rc = pick_vec();
            step(($urandom_range(0, 9) != 0), $urandom_range(0, 31), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), ra, rb, rc, $urandom());
        end
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule